// File: doc/BRIEF.md
# Console CPU Bus Address Decoder

This block sits on the 16-bit address bus of an 8-bit console processor and turns each bus address into one target select and a translated local address. The low 8 KiB of the map reaches a 2 KiB work RAM, which therefore appears four times. The next 8 KiB reaches a window of eight peripheral registers that repeats every eight bytes. The upper 32 KiB reaches the program ROM. The gap between 0x4000 and 0x7FFF is reported as unmapped so that logic outside the block can claim it. A configuration input selects a ROM of 16 KiB or 32 KiB. A 16 KiB image is seen twice, once at 0x8000 and again at 0xC000.

The decode is purely combinational. The block also muxes the read data of the selected target back to the processor. Writes that land in ROM never reach a target, and a one-cycle flag records each such attempt. A small helper can fetch a 16-bit little-endian value. It spends two bus cycles reading the byte at the request address and then the byte that follows, and it presents the assembled word in the cycle after that.

Top module: `cpubus_decoder`

## Requirements
- R1: An effective address below 0x2000 asserts ramSel, and ramAddr equals address bits [10:0], so RAM repeats every 0x800 bytes.
- R2: An effective address in 0x2000–0x3FFF asserts regSel, and regAddr equals address bits [2:0]. In that window regRd follows the read strobe and regWr follows the effective write strobe.
- R3: An effective address of 0x8000 or above asserts romSel. romAddr equals address bits [14:0] when romIs32k is 1. It equals bits [13:0] with bit 14 forced to 0 when romIs32k is 0.
- R4: An effective address in 0x4000–0x7FFF asserts unmapped, and cpuRdData is 0xFF there.
- R5: For every address, exactly one of ramSel, regSel, romSel and unmapped is 1.
- R6: cpuRdData equals ramRdData, regRdData or romRdData, whichever target is selected.
- R7: ramWr is 1 only for a RAM-region effective write. regWr is 1 only for a register-window effective write. A write to ROM or to unmapped space raises neither.
- R8: romWrFlag is 1 in exactly the cycle after a cycle that carried an effective write in the ROM region, and 0 otherwise.
- R9: A wordReq sampled while wordBusy is 0 starts a fetch. Two clock edges later, wordValid is 1 for a single cycle and wordData is {byte at A+1, byte at A}. A+1 wraps modulo 2^16, and each byte goes through the same mirroring as a plain access.
- R10: While wordBusy is 1, the effective address is the latched A+1, and cpuWr and wordReq are ignored. A write is also ignored in the request cycle itself, which counts as a read.
- R11: After reset, romWrFlag, wordValid and wordBusy are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | Processor bus address |
| cpuRd | input | 1 | Processor read strobe |
| cpuWr | input | 1 | Processor write strobe |
| romIs32k | input | 1 | 1: 32 KiB ROM, 0: 16 KiB ROM mirrored |
| wordReq | input | 1 | Start a two-byte little-endian fetch at cpuAddr |
| ramRdData | input | 8 | Read data from work RAM |
| regRdData | input | 8 | Read data from peripheral window |
| romRdData | input | 8 | Read data from program ROM |
| ramSel | output | 1 | RAM region selected |
| ramWr | output | 1 | RAM write strobe |
| ramAddr | output | 11 | RAM local address |
| regSel | output | 1 | Register window selected |
| regRd | output | 1 | Register read strobe |
| regWr | output | 1 | Register write strobe |
| regAddr | output | 3 | Register index |
| romSel | output | 1 | ROM region selected |
| romAddr | output | 15 | ROM offset |
| unmapped | output | 1 | Address hits no target |
| cpuRdData | output | 8 | Read data returned to the processor |
| romWrFlag | output | 1 | Pulse after a write attempt to ROM |
| wordBusy | output | 1 | Second byte of a word fetch in progress |
| wordValid | output | 1 | wordData holds a completed fetch |
| wordData | output | 16 | Assembled little-endian word |

## Verification
The bench sweeps every fifth address across the whole map, once for each ROM size. Region edges such as 0x1FFF/0x2000, 0x3FFF/0x4000, 0x7FFF/0x8000 and 0xBFFF/0xC000 get targeted checks. An off-by-one boundary or a wrong mask width would select the wrong target there, or would return a byte from the wrong mirror. Word fetches that straddle 0x07FF, 0xBFFF and 0xFFFF catch a design that forgets to wrap the second address or to mirror it. A design that let a write through during the second fetch cycle would show a RAM strobe. Writes to ROM and to unmapped space test that no strobe leaks out and that the flag pulses for exactly one cycle.

// File: rtl/cpubus_pkg.sv
package cpubus_pkg;

  typedef enum logic [1:0] {
    RGN_RAM   = 2'd0,
    RGN_REGS  = 2'd1,
    RGN_UNMAP = 2'd2,
    RGN_ROM   = 2'd3
  } region_e;

  typedef struct packed {
    logic selRam;
    logic selRegs;
    logic selRom;
    logic selUnmap;
    logic useNext;
    logic grabLow;
    logic grabHigh;
  } busStrobe_t;

endpackage

// File: rtl/cpubus_region.sv
module cpubus_region
  import cpubus_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           rgn
);
  localparam int TOP = ADDR_W - 1;

  // Top bit set: ROM half. Otherwise the next two bits pick an 8 KiB slice.
  always_comb begin
    if (addr[TOP]) begin
      rgn = RGN_ROM;
    end else begin
      unique case (addr[TOP-1:TOP-2])
        2'b00:   rgn = RGN_RAM;
        2'b01:   rgn = RGN_REGS;
        default: rgn = RGN_UNMAP;
      endcase
    end
  end
endmodule

// File: rtl/cpubus_ctrl.sv
module cpubus_ctrl
  import cpubus_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic              wordReq,
  output busStrobe_t        strobe,
  output logic              wrEff,
  output logic              rdEff,
  output logic              wordBusy,
  output logic              wordValid,
  output logic              romWrFlag
);
  typedef enum logic {ST_IDLE, ST_HIGH} fetch_e;

  fetch_e  state, stateNxt;
  region_e rgn;
  logic    idle;

  cpubus_region #(.ADDR_W(ADDR_W)) region_i (
    .addr (effAddr),
    .rgn  (rgn)
  );

  assign idle = (state == ST_IDLE);

  always_comb begin
    strobe          = '0;
    strobe.selRam   = (rgn == RGN_RAM);
    strobe.selRegs  = (rgn == RGN_REGS);
    strobe.selRom   = (rgn == RGN_ROM);
    strobe.selUnmap = (rgn == RGN_UNMAP);
    strobe.useNext  = !idle;
    strobe.grabLow  = idle && wordReq;
    strobe.grabHigh = !idle;
    stateNxt = state;
    if (idle && wordReq) stateNxt = ST_HIGH;
    else if (!idle)      stateNxt = ST_IDLE;
  end

  // A word fetch owns the bus for both of its cycles; writes are dropped.
  assign wrEff    = idle && cpuWr && !wordReq;
  assign rdEff    = !idle || cpuRd || wordReq;
  assign wordBusy = !idle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wordValid <= 1'b0;
      romWrFlag <= 1'b0;
    end else begin
      state     <= stateNxt;
      wordValid <= strobe.grabHigh;
      romWrFlag <= strobe.selRom && wrEff;
    end
  end
endmodule

// File: rtl/cpubus_dpath.sv
module cpubus_dpath
  import cpubus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 11,
  parameter int REG_AW = 3,
  parameter int ROM_AW = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic                romIs32k,
  input  busStrobe_t          strobe,
  input  logic [DATA_W-1:0]   ramRdData,
  input  logic [DATA_W-1:0]   regRdData,
  input  logic [DATA_W-1:0]   romRdData,
  output logic [ADDR_W-1:0]   effAddr,
  output logic [RAM_AW-1:0]   ramAddr,
  output logic [REG_AW-1:0]   regAddr,
  output logic [ROM_AW-1:0]   romAddr,
  output logic [DATA_W-1:0]   cpuRdData,
  output logic [2*DATA_W-1:0] wordData
);
  localparam int HALF_MSB = ROM_AW - 1;

  logic [ADDR_W-1:0] nextAddr;
  logic [DATA_W-1:0] lowByte;

  assign effAddr = strobe.useNext ? nextAddr : cpuAddr;

  // Mirroring is a plain truncation of the effective address.
  assign ramAddr = effAddr[RAM_AW-1:0];
  assign regAddr = effAddr[REG_AW-1:0];

  always_comb begin
    romAddr = effAddr[ROM_AW-1:0];
    if (!romIs32k) romAddr[HALF_MSB] = 1'b0;
  end

  always_comb begin
    cpuRdData = '1;
    if (strobe.selRam)       cpuRdData = ramRdData;
    else if (strobe.selRegs) cpuRdData = regRdData;
    else if (strobe.selRom)  cpuRdData = romRdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextAddr <= '0;
      lowByte  <= '0;
      wordData <= '0;
    end else begin
      if (strobe.grabLow) begin
        nextAddr <= effAddr + 1'b1;
        lowByte  <= cpuRdData;
      end
      if (strobe.grabHigh) wordData <= {cpuRdData, lowByte};
    end
  end
endmodule

// File: rtl/cpubus_decoder.sv
module cpubus_decoder
  import cpubus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 11,
  parameter int REG_AW = 3,
  parameter int ROM_AW = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic                cpuRd,
  input  logic                cpuWr,
  input  logic                romIs32k,
  input  logic                wordReq,
  input  logic [DATA_W-1:0]   ramRdData,
  input  logic [DATA_W-1:0]   regRdData,
  input  logic [DATA_W-1:0]   romRdData,
  output logic                ramSel,
  output logic                ramWr,
  output logic [RAM_AW-1:0]   ramAddr,
  output logic                regSel,
  output logic                regRd,
  output logic                regWr,
  output logic [REG_AW-1:0]   regAddr,
  output logic                romSel,
  output logic [ROM_AW-1:0]   romAddr,
  output logic                unmapped,
  output logic [DATA_W-1:0]   cpuRdData,
  output logic                romWrFlag,
  output logic                wordBusy,
  output logic                wordValid,
  output logic [2*DATA_W-1:0] wordData
);
  busStrobe_t        strobe;
  logic [ADDR_W-1:0] effAddr;
  logic              wrEff;
  logic              rdEff;

  cpubus_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .effAddr   (effAddr),
    .cpuRd     (cpuRd),
    .cpuWr     (cpuWr),
    .wordReq   (wordReq),
    .strobe    (strobe),
    .wrEff     (wrEff),
    .rdEff     (rdEff),
    .wordBusy  (wordBusy),
    .wordValid (wordValid),
    .romWrFlag (romWrFlag)
  );

  cpubus_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_AW(RAM_AW),
    .REG_AW(REG_AW), .ROM_AW(ROM_AW)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .cpuAddr   (cpuAddr),
    .romIs32k  (romIs32k),
    .strobe    (strobe),
    .ramRdData (ramRdData),
    .regRdData (regRdData),
    .romRdData (romRdData),
    .effAddr   (effAddr),
    .ramAddr   (ramAddr),
    .regAddr   (regAddr),
    .romAddr   (romAddr),
    .cpuRdData (cpuRdData),
    .wordData  (wordData)
  );

  assign ramSel   = strobe.selRam;
  assign regSel   = strobe.selRegs;
  assign romSel   = strobe.selRom;
  assign unmapped = strobe.selUnmap;
  assign ramWr    = strobe.selRam  && wrEff;
  assign regWr    = strobe.selRegs && wrEff;
  assign regRd    = strobe.selRegs && rdEff;
endmodule

// File: rtl/cpubus_decoder_chk.sv
module cpubus_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuWr,
  input logic              wordReq,
  input logic              ramSel,
  input logic              ramWr,
  input logic [RAM_AW-1:0] ramAddr,
  input logic              regSel,
  input logic              regWr,
  input logic              romSel,
  input logic              unmapped,
  input logic [DATA_W-1:0] cpuRdData,
  input logic              romWrFlag,
  input logic              wordBusy,
  input logic              wordValid
);
  assert_one_target_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({ramSel, regSel, romSel, unmapped}));

  assert_unmapped_ff_R4: assert property (@(posedge clk) disable iff (!rstN)
    unmapped |-> cpuRdData == '1);

  assert_ram_mirror_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ramSel && !wordBusy) |-> ramAddr == cpuAddr[RAM_AW-1:0]);

  assert_rom_blocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (romSel || unmapped) |-> !(ramWr || regWr));

  assert_flag_after_rom_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (romSel && cpuWr && !wordBusy && !wordReq) |=> romWrFlag);

  assert_word_completes_R9: assert property (@(posedge clk) disable iff (!rstN)
    wordBusy |=> (wordValid && !wordBusy));

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  assert_busy_no_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    wordBusy |-> !(ramWr || regWr));
endmodule

bind cpubus_decoder cpubus_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RAM_AW(RAM_AW)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cpuAddr   (cpuAddr),
  .cpuWr     (cpuWr),
  .wordReq   (wordReq),
  .ramSel    (ramSel),
  .ramWr     (ramWr),
  .ramAddr   (ramAddr),
  .regSel    (regSel),
  .regWr     (regWr),
  .romSel    (romSel),
  .unmapped  (unmapped),
  .cpuRdData (cpuRdData),
  .romWrFlag (romWrFlag),
  .wordBusy  (wordBusy),
  .wordValid (wordValid)
);

// File: tb/cpubus_decoder_tb_top.sv
module cpubus_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        cpuRd = 1'b0;
  logic        cpuWr = 1'b0;
  logic        romIs32k = 1'b0;
  logic        wordReq = 1'b0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  ramRdData, regRdData, romRdData;
  logic        ramSel, ramWr, regSel, regRd, regWr, romSel, unmapped;
  logic [10:0] ramAddr;
  logic [2:0]  regAddr;
  logic [14:0] romAddr;
  logic [7:0]  cpuRdData;
  logic        romWrFlag, wordBusy, wordValid;
  logic [15:0] wordData;

  logic [7:0] ram [0:2047];
  logic [7:0] regFile [0:7];

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] romByte(logic [14:0] o);
    return o[7:0] ^ {1'b0, o[14:8]} ^ 8'h3C;
  endfunction

  assign ramRdData = ram[ramAddr];
  assign regRdData = regFile[regAddr];
  assign romRdData = romByte(romAddr);

  always @(posedge clk) begin
    if (ramWr) ram[ramAddr] <= cpuWrData;
    if (regWr) regFile[regAddr] <= cpuWrData;
  end

  cpubus_decoder dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .romIs32k(romIs32k), .wordReq(wordReq), .ramRdData(ramRdData),
    .regRdData(regRdData), .romRdData(romRdData), .ramSel(ramSel), .ramWr(ramWr),
    .ramAddr(ramAddr), .regSel(regSel), .regRd(regRd), .regWr(regWr),
    .regAddr(regAddr), .romSel(romSel), .romAddr(romAddr), .unmapped(unmapped),
    .cpuRdData(cpuRdData), .romWrFlag(romWrFlag), .wordBusy(wordBusy),
    .wordValid(wordValid), .wordData(wordData)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // 0 RAM, 1 registers, 2 unmapped, 3 ROM
  function automatic int expRegion(int a);
    if (a < 'h2000) return 0;
    if (a < 'h4000) return 1;
    if (a < 'h8000) return 2;
    return 3;
  endfunction

  function automatic int expRomOff(int a, bit is32);
    return is32 ? (a - 'h8000) : ((a - 'h8000) % 'h4000);
  endfunction

  function automatic logic [7:0] memByte(int a, bit is32);
    case (expRegion(a))
      0: return ram[a % 'h800];
      1: return regFile[a % 8];
      2: return 8'hFF;
      default: return romByte(15'(expRomOff(a, is32)));
    endcase
  endfunction

  function automatic string regionTag(int r);
    case (r)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic probe(input int a, input bit is32);
    int r;
    logic [3:0] expSel;
    @(negedge clk);
    cpuAddr = a[15:0]; romIs32k = is32; cpuRd = 1'b1;
    #1;
    r = expRegion(a);
    expSel = 4'b1000 >> r;
    check({ramSel, regSel, unmapped, romSel} == expSel, "R5 select", {ramSel, regSel, unmapped, romSel}, expSel);
    case (r)
      0: check(ramAddr == 11'(a % 'h800), "R1 ramAddr", ramAddr, a % 'h800);
      1: begin
        check(regAddr == 3'(a % 8), "R2 regAddr", regAddr, a % 8);
        check(regRd == 1'b1, "R2 regRd", regRd, 1);
      end
      2: check(cpuRdData == 8'hFF, "R4 open bus", cpuRdData, 'hFF);
      default: check(romAddr == 15'(expRomOff(a, is32)), "R3 romAddr", romAddr, expRomOff(a, is32));
    endcase
    check(cpuRdData == memByte(a, is32), {"R6 data ", regionTag(r)}, cpuRdData, memByte(a, is32));
  endtask

  task automatic wordFetch(input int a, input bit is32);
    int a1;
    logic [15:0] exp;
    a1 = (a + 1) % 'h10000;
    exp = {memByte(a1, is32), memByte(a, is32)};
    @(negedge clk);
    cpuAddr = a[15:0]; romIs32k = is32; wordReq = 1'b1; cpuRd = 1'b0; cpuWr = 1'b0;
    @(negedge clk);
    wordReq = 1'b1; cpuWr = 1'b1; cpuWrData = 8'hEE; cpuAddr = 16'h0003;
    #1;
    check(wordBusy == 1'b1, "R10 busy", wordBusy, 1);
    check(!ramWr && !regWr, "R10 write dropped", {ramWr, regWr}, 0);
    check(cpuRdData == memByte(a1, is32), "R10 next address", cpuRdData, memByte(a1, is32));
    @(negedge clk);
    wordReq = 1'b0; cpuWr = 1'b0;
    #1;
    check(wordValid == 1'b1, "R9 valid", wordValid, 1);
    check(wordData == exp, "R9 word", wordData, exp);
    check(wordBusy == 1'b0, "R10 wordReq ignored while busy", wordBusy, 0);
    @(negedge clk);
    #1;
    check(wordValid == 1'b0, "R9 single pulse", wordValid, 0);
  endtask

  initial begin
    int edges [9] = '{'h1FFF, 'h2000, 'h3FFF, 'h4000, 'h7FFF, 'h8000, 'hBFFF, 'hC000, 'hFFFF};
    for (int i = 0; i < 2048; i++) ram[i] = 8'(i * 7 + 1);
    for (int i = 0; i < 8; i++) regFile[i] = 8'(8'hA0 + i);

    repeat (3) @(negedge clk);
    #1;
    check(romWrFlag == 1'b0, "R11 flag", romWrFlag, 0);
    check(wordValid == 1'b0, "R11 valid", wordValid, 0);
    check(wordBusy == 1'b0, "R11 busy", wordBusy, 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int cfg = 0; cfg < 2; cfg++) begin
      for (int a = 0; a < 'h10000; a += 5) probe(a, cfg[0]);
      for (int k = 0; k < 9; k++) probe(edges[k], cfg[0]);
    end

    // RAM write through a mirror, read back through another (R7, R1)
    @(negedge clk);
    cpuRd = 1'b0; cpuAddr = 16'h1805; cpuWr = 1'b1; cpuWrData = 8'h5A;
    #1;
    check(ramWr == 1'b1 && ramAddr == 11'h005, "R7 ram write", {ramWr, ramAddr}, 'h805);
    @(negedge clk);
    cpuWr = 1'b0; cpuAddr = 16'h0805; cpuRd = 1'b1;
    #1;
    check(cpuRdData == 8'h5A, "R1 mirror readback", cpuRdData, 'h5A);
    check(romWrFlag == 1'b0, "R8 no flag for ram", romWrFlag, 0);

    // register write and read strobes (R2, R7)
    @(negedge clk);
    cpuRd = 1'b0; cpuAddr = 16'h3FFA; cpuWr = 1'b1; cpuWrData = 8'h66;
    #1;
    check(regWr == 1'b1 && regAddr == 3'd2, "R7 reg write", {regWr, regAddr}, 'hA);
    check(regRd == 1'b0, "R2 no read strobe", regRd, 0);
    @(negedge clk);
    cpuWr = 1'b0; cpuAddr = 16'h200A; cpuRd = 1'b1;
    #1;
    check(cpuRdData == 8'h66 && regRd == 1'b1, "R2 reg readback", cpuRdData, 'h66);

    // ROM write blocked, flag pulses once (R7, R8)
    @(negedge clk);
    cpuRd = 1'b0; cpuAddr = 16'h9123; cpuWr = 1'b1; cpuWrData = 8'h11;
    #1;
    check(!ramWr && !regWr, "R7 rom write blocked", {ramWr, regWr}, 0);
    check(romWrFlag == 1'b0, "R8 flag not early", romWrFlag, 0);
    @(negedge clk);
    cpuWr = 1'b0;
    #1;
    check(romWrFlag == 1'b1, "R8 flag raised", romWrFlag, 1);
    @(negedge clk);
    #1;
    check(romWrFlag == 1'b0, "R8 flag one cycle", romWrFlag, 0);

    // unmapped write: no strobe, no flag (R7, R8)
    @(negedge clk);
    cpuAddr = 16'h6000; cpuWr = 1'b1;
    #1;
    check(!ramWr && !regWr, "R7 unmapped write", {ramWr, regWr}, 0);
    @(negedge clk);
    cpuWr = 1'b0;
    #1;
    check(romWrFlag == 1'b0, "R8 no flag for unmapped", romWrFlag, 0);

    // word fetches across boundaries (R9, R10)
    wordFetch('h0010, 1'b0);
    wordFetch('h07FF, 1'b0);
    wordFetch('h3FFF, 1'b0);
    wordFetch('hBFFF, 1'b0);
    wordFetch('hBFFF, 1'b1);
    wordFetch('hFFFF, 1'b0);
    wordFetch('hFFFC, 1'b1);

    // RAM must be untouched by the dropped write at 0x0003 (R10)
    @(negedge clk);
    cpuAddr = 16'h0003; cpuRd = 1'b1;
    #1;
    check(cpuRdData == 8'(3 * 7 + 1), "R10 ram unchanged", cpuRdData, 3 * 7 + 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule